// File: doc/BRIEF.md
# Interrupt Priority Level Arbiter

This block picks the interrupt a processor takes at an instruction boundary. It only acts when no trap is pending. Two kinds of source take part. Bus devices raise a request at one of the levels 4 to 7, and each of them supplies its own vector. A software-written request register holds one request bit per level from 1 to 7, plus a three-bit field that names the highest programmed level.

The arbiter walks the levels from 7 down to one above the current processor priority and stops at the first level that has a request. At each level the programmed request is looked at before the bus request. If that walk finds nothing, the priority field of the register can still raise a programmed interrupt.

The arbiter registers its decision on the boundary strobe. One cycle later it presents the vector, the winning level, a one-cycle acknowledge to the bus requester it chose, and a wake pulse when a bus interrupt ends a wait-for-interrupt state. Bus requests are level-sensitive and are never latched inside the arbiter.

Top module: `ipl_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, grantValid, ackBus and wakeUp are 0.
- R2: Levels are scanned from 7 down to cpuPriority+1. The highest level with a request wins, and a granted level is always above cpuPriority.
- R3: At a level L that has both a programmed request (pirqReg bit 8+L) and a bus request, the programmed request wins and ackBus stays 0.
- R4: Every programmed grant carries vector 0x00A0.
- R5: A bus grant at level L carries busVec[L-4] and pulses ackBus bit L-4 (and only that bit) for exactly one cycle.
- R6: While trapPending is 1 at the boundary, no grant, acknowledge or wake is produced.
- R7: When the scan finds nothing and pirqReg[3:1] > cpuPriority, a programmed grant is made at level pirqReg[3:1].
- R8: A decision is sampled only on a cycle with boundary=1. Its outputs appear in the next cycle for one cycle only. No grant is made in the cycle right after a grant.
- R9: wakeUp pulses together with a bus grant when inWait was 1 at the boundary. A programmed grant never pulses wakeUp.
- R10: With no request above cpuPriority (including cpuPriority=7), no grant is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction-boundary strobe |
| trapPending | input | 1 | A trap is waiting; blocks interrupts |
| inWait | input | 1 | Processor is in the wait-for-interrupt state |
| cpuPriority | input | 3 | Current processor priority |
| busReq | input | 4 | Bus requests; bit i is level i+4 |
| busVec | input | 4x16 | Device vectors; entry i belongs to level i+4 |
| pirqReg | input | 16 | Programmed request register: bits 15:9 per level, bits 3:1 level field |
| grantValid | output | 1 | One-cycle pulse: an interrupt was granted |
| grantLevel | output | 3 | Level of the granted interrupt |
| grantVector | output | 16 | Vector of the granted interrupt |
| ackBus | output | 4 | One-hot acknowledge to the chosen bus requester |
| wakeUp | output | 1 | Leave the wait state |

## Verification
Four properties are checked on every cycle. A grant only follows an untrapped boundary and sits above the priority sampled at that boundary. The acknowledge is one-hot, lasts one cycle and comes only with a valid grant. A programmed grant always carries 0x00A0. What cannot be seen cycle by cycle is left to the bench scenarios: the order of the scan, the programmed source winning a tie, the fallback to the level field, and the choice of device vector.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int LEVELS  = 8;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int BUS_LO  = 4;
  localparam int NBUS    = LEVELS - BUS_LO;
  localparam int BIDX_W  = $clog2(NBUS);
  localparam int PBASE   = 8;
  localparam int PIRQ_W  = PBASE + LEVELS;
  localparam int VEC_W   = 16;

  typedef struct packed {
    logic             take;
    logic             isBus;
    logic [LVL_W-1:0] level;
  } pickStrobe_t;
endpackage

// File: rtl/ipl_ctrl.sv
module ipl_ctrl
  import ipl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              boundary,
  input  logic              trapPending,
  input  logic [LVL_W-1:0]  cpuPriority,
  input  logic [NBUS-1:0]   busReq,
  input  logic [PIRQ_W-1:0] pirqReg,
  output pickStrobe_t       pick
);
  logic             found;
  logic             foundBus;
  logic [LVL_W-1:0] foundLvl;
  logic [LVL_W-1:0] fieldLvl;
  logic             lastTake;
  logic             eligible;

  assign fieldLvl = pirqReg[LVL_W:1];

  // Scan from the top level down; programmed bit before bus request.
  always_comb begin
    found    = 1'b0;
    foundBus = 1'b0;
    foundLvl = '0;
    for (int l = LEVELS - 1; l >= 1; l--) begin
      if (!found && (LVL_W'(l) > cpuPriority)) begin
        if (pirqReg[PBASE + l]) begin
          found    = 1'b1;
          foundLvl = LVL_W'(l);
        end else if (l >= BUS_LO && busReq[BIDX_W'(l - BUS_LO)]) begin
          found    = 1'b1;
          foundBus = 1'b1;
          foundLvl = LVL_W'(l);
        end
      end
    end
    if (!found && (fieldLvl > cpuPriority)) begin
      found    = 1'b1;
      foundLvl = fieldLvl;
    end
  end

  assign eligible = boundary && !trapPending && !lastTake;

  always_comb begin
    pick.take  = eligible && found;
    pick.isBus = eligible && found && foundBus;
    pick.level = foundLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastTake <= 1'b0;
    else       lastTake <= pick.take;
  end

  // R8: never two takes back to back
  p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (!rstN)
    pick.take |=> !pick.take);
endmodule

// File: rtl/ipl_datapath.sv
module ipl_datapath
  import ipl_pkg::*;
#(
  parameter logic [VEC_W-1:0] PIRQ_VEC = 16'h00A0
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  pickStrobe_t                pick,
  input  logic                       inWait,
  input  logic [NBUS-1:0][VEC_W-1:0] busVec,
  output logic                       grantValid,
  output logic [LVL_W-1:0]           grantLevel,
  output logic [VEC_W-1:0]           grantVector,
  output logic [NBUS-1:0]            ackBus,
  output logic                       wakeUp
);
  logic [LVL_W-1:0]  busOff;
  logic [BIDX_W-1:0] busIdx;
  logic [VEC_W-1:0]  vecSel;

  assign busOff = pick.level - LVL_W'(BUS_LO);
  assign busIdx = busOff[BIDX_W-1:0];
  assign vecSel = pick.isBus ? busVec[busIdx] : PIRQ_VEC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid  <= 1'b0;
      grantLevel  <= '0;
      grantVector <= '0;
      ackBus      <= '0;
      wakeUp      <= 1'b0;
    end else begin
      grantValid <= pick.take;
      wakeUp     <= pick.isBus && inWait;
      ackBus     <= '0;
      if (pick.take) begin
        grantLevel  <= pick.level;
        grantVector <= vecSel;
      end
      if (pick.isBus) ackBus[busIdx] <= 1'b1;
    end
  end

  // R5: acknowledge is one-hot and only with a grant
  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($onehot0(ackBus) && (|ackBus -> grantValid)));
  // R5: acknowledge lasts a single cycle
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    |ackBus |=> ackBus == '0);
  // R4: a programmed grant carries the fixed vector
  p_pirq_vector_r4: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && ackBus == '0) |-> grantVector == PIRQ_VEC);
  // R9: wake only with a bus acknowledge
  p_wake_bus_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> |ackBus);
endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter
  import ipl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       boundary,
  input  logic                       trapPending,
  input  logic                       inWait,
  input  logic [LVL_W-1:0]           cpuPriority,
  input  logic [NBUS-1:0]            busReq,
  input  logic [NBUS-1:0][VEC_W-1:0] busVec,
  input  logic [PIRQ_W-1:0]          pirqReg,
  output logic                       grantValid,
  output logic [LVL_W-1:0]           grantLevel,
  output logic [VEC_W-1:0]           grantVector,
  output logic [NBUS-1:0]            ackBus,
  output logic                       wakeUp
);
  pickStrobe_t pick;

  ipl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .trapPending(trapPending),
    .cpuPriority(cpuPriority), .busReq(busReq), .pirqReg(pirqReg), .pick(pick)
  );

  ipl_datapath uData (
    .clk(clk), .rstN(rstN), .pick(pick), .inWait(inWait), .busVec(busVec),
    .grantValid(grantValid), .grantLevel(grantLevel), .grantVector(grantVector),
    .ackBus(ackBus), .wakeUp(wakeUp)
  );

  // R6/R8: a grant follows an untrapped boundary
  p_grant_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ($past(boundary) && !$past(trapPending)));
  // R2: granted level is above the priority at the boundary
  p_level_above_r2: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantLevel > $past(cpuPriority)));
endmodule

// File: tb/tb_ipl_arbiter.sv
module tb_ipl_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic boundary = 1'b0, trapPending = 1'b0, inWait = 1'b0;
  logic [2:0] cpuPriority = '0;
  logic [3:0] busReq = '0;
  logic [3:0][15:0] busVec;
  logic [15:0] pirqReg = '0;
  logic grantValid, wakeUp;
  logic [2:0] grantLevel;
  logic [15:0] grantVector;
  logic [3:0] ackBus;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipl_arbiter dut (
    .clk(clk), .rstN(rstN), .boundary(boundary), .trapPending(trapPending),
    .inWait(inWait), .cpuPriority(cpuPriority), .busReq(busReq), .busVec(busVec),
    .pirqReg(pirqReg), .grantValid(grantValid), .grantLevel(grantLevel),
    .grantVector(grantVector), .ackBus(ackBus), .wakeUp(wakeUp)
  );

  typedef struct packed {
    logic [2:0]  pri;
    logic [3:0]  bus;
    logic [15:0] pirq;
    logic        trap;
    logic        ev;
    logic [2:0]  el;
    logic [15:0] evec;
    logic [3:0]  eack;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 4'b0001, 16'h0000, 1'b0, 1'b1, 3'd4, 16'h0050, 4'b0001, 8'd5},  // R5
    '{3'd0, 4'b1010, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h005C, 4'b1000, 8'd2},  // R2
    '{3'd5, 4'b0011, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 4'b0000, 8'd10}, // R10
    '{3'd5, 4'b0100, 16'h0000, 1'b0, 1'b1, 3'd6, 16'h0058, 4'b0100, 8'd2},  // R2
    '{3'd0, 4'b0100, 16'h4000, 1'b0, 1'b1, 3'd6, 16'h00A0, 4'b0000, 8'd3},  // R3
    '{3'd0, 4'b0100, 16'h8000, 1'b0, 1'b1, 3'd7, 16'h00A0, 4'b0000, 8'd2},  // R2
    '{3'd0, 4'b1000, 16'h2000, 1'b0, 1'b1, 3'd7, 16'h005C, 4'b1000, 8'd2},  // R2
    '{3'd2, 4'b0000, 16'h0800, 1'b0, 1'b1, 3'd3, 16'h00A0, 4'b0000, 8'd4},  // R4
    '{3'd3, 4'b0000, 16'h0800, 1'b0, 1'b0, 3'd0, 16'h0000, 4'b0000, 8'd10}, // R10
    '{3'd2, 4'b0000, 16'h000A, 1'b0, 1'b1, 3'd5, 16'h00A0, 4'b0000, 8'd7},  // R7
    '{3'd5, 4'b0000, 16'h000A, 1'b0, 1'b0, 3'd0, 16'h0000, 4'b0000, 8'd7},  // R7
    '{3'd0, 4'b1111, 16'hFE0E, 1'b1, 1'b0, 3'd0, 16'h0000, 4'b0000, 8'd6},  // R6
    '{3'd6, 4'b0100, 16'h000E, 1'b0, 1'b1, 3'd7, 16'h00A0, 4'b0000, 8'd7},  // R7
    '{3'd0, 4'b0001, 16'h0006, 1'b0, 1'b1, 3'd4, 16'h0050, 4'b0001, 8'd2},  // R2
    '{3'd7, 4'b1111, 16'hFE0E, 1'b0, 1'b0, 3'd0, 16'h0000, 4'b0000, 8'd10}  // R10
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkOut(input int req, input logic ev, input logic [2:0] el,
                          input logic [15:0] evec, input logic [3:0] eack,
                          input logic ew);
    check(grantValid === ev, req, "grantValid", 32'(grantValid), 32'(ev));
    if (ev) begin
      check(grantLevel === el, req, "grantLevel", 32'(grantLevel), 32'(el));
      check(grantVector === evec, req, "grantVector", 32'(grantVector), 32'(evec));
    end
    check(ackBus === eack, req, "ackBus", 32'(ackBus), 32'(eack));
    check(wakeUp === ew, req, "wakeUp", 32'(wakeUp), 32'(ew));
  endtask

  // drive at negedge, pulse boundary one cycle, sample at next negedge
  task automatic strobe();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) busVec[i] = 16'h0040 + 16'((i + 4) * 4);
    repeat (3) @(negedge clk);
    checkOut(1, 1'b0, 3'd0, 16'h0, 4'b0, 1'b0);          // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1, 1'b0, 3'd0, 16'h0, 4'b0, 1'b0);          // R1 after release

    for (int k = 0; k < NV; k++) begin
      cpuPriority = TBL[k].pri; busReq = TBL[k].bus;
      pirqReg = TBL[k].pirq; trapPending = TBL[k].trap;
      strobe();
      checkOut(int'(TBL[k].req), TBL[k].ev, TBL[k].el, TBL[k].evec, TBL[k].eack, 1'b0);
      trapPending = 1'b0;
      @(negedge clk);
      checkOut(8, 1'b0, 3'd0, 16'h0, 4'b0, 1'b0);        // R8 pulse ends
    end

    // R8: requests without boundary give nothing
    cpuPriority = 3'd0; busReq = 4'b1000; pirqReg = 16'h0;
    @(negedge clk); @(negedge clk);
    checkOut(8, 1'b0, 3'd0, 16'h0, 4'b0, 1'b0);

    // R8: boundary held two cycles grants once
    boundary = 1'b1;
    @(negedge clk);
    checkOut(8, 1'b1, 3'd7, 16'h005C, 4'b1000, 1'b0);
    @(negedge clk);
    boundary = 1'b0;
    checkOut(8, 1'b0, 3'd0, 16'h0, 4'b0, 1'b0);
    @(negedge clk);

    // R9: wake on bus grant while waiting
    inWait = 1'b1; busReq = 4'b0010;
    strobe();
    checkOut(9, 1'b1, 3'd5, 16'h0054, 4'b0010, 1'b1);
    @(negedge clk);
    // R9: programmed grant does not wake
    busReq = 4'b0000; pirqReg = 16'h0200;
    strobe();
    checkOut(9, 1'b1, 3'd1, 16'h00A0, 4'b0000, 1'b0);
    inWait = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R8 watchdog actual=hung expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule